// File: doc/BRIEF.md
# Word Serializer with Wrap Loopback

This block turns a stream of 20-bit parallel words into a serial bit stream on a single bit clock. Each word holds two transmission characters that are already line coded upstream. A free-running phase counter raises a one-cycle `word_load` strobe every twentieth bit clock. On that edge the block captures `word_in` and then shifts it out over the next twenty cycles, least significant bit first. Words follow one another with no gap and no idle bit between them.

A wrap control diverts the serial stream away from the line. With `wrap_en` high, the line pair is parked at the idle level (positive leg high, negative leg low). The serial stream then goes to `rx_bit`, which feeds the local receiver in place of the external line input. With `wrap_en` low, the line pair carries the data and `rx_bit` follows `line_rx_in`. The wrap control changes only where the bits go. The shifter keeps counting and shifting while wrap is high.

The reset is asynchronous and active low, and its release is synchronised inside the block. From reset until the first word has been captured, the line and the loopback path both sit at the idle level.

Top module: `ser_wrap_tx`

## Requirements
- R1: While reset is asserted, and afterwards until the first word is captured, `line_p`=1 and `line_n`=0, and `word_load` stays 0 while reset is asserted.
- R2: `word_load` is high for exactly one cycle. Consecutive pulses are exactly 20 bit-clock cycles apart.
- R3: `word_in` is captured only at the rising edge where `word_load` is high. Its value at any other edge has no effect on the serial bits that follow.
- R4: Bit k (k = 0..19) of a captured word is the serial bit in the (k+1)-th cycle after the capture edge. Bit 0 goes first, bit 19 goes last, and the next word's bit 0 follows directly.
- R5: Bits 0..9 form the first character and bits 10..19 the second. Each character goes out in the order a,b,c,d,e,i,f,g,h,j, which occupy bits 0..9 of that character. Bit 9 is therefore followed directly by bit 10.
- R6: Whenever `wrap_en` is 1, `line_p`=1 and `line_n`=0 in that same cycle, whatever the data.
- R7: When `wrap_en` is 1, `rx_bit` equals the current serial bit. When `wrap_en` is 0, `rx_bit` equals `line_rx_in`.
- R8: When `wrap_en` is 0 and a word has been captured, `line_p` equals the current serial bit and `line_n` is its complement.
- R9: Toggling `wrap_en` does not pause, repeat or skip serial bits. After wrap drops, the line resumes at the bit position that the timing in R4 gives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| word_in | input | 20 | Parallel word; bit 0 is sent first |
| wrap_en | input | 1 | 1 = internal loopback with the line held idle; 0 = normal line operation |
| line_rx_in | input | 1 | Serial input from the external line, for the receiver |
| word_load | output | 1 | One-cycle strobe; `word_in` is captured at the next rising edge |
| line_p | output | 1 | Positive leg of the serial line output |
| line_n | output | 1 | Negative leg of the serial line output |
| rx_bit | output | 1 | Serial bit routed to the receiver (loopback or external input) |

## Verification
Two things can happen in the same cycle: a word load and a change of `wrap_en`. A change of `wrap_en` can also land partway through a word. The bench provokes both with stretches in which `wrap_en` flips at random on many cycles, in addition to steady wrap and steady line phases. It judges every cycle against a reference word captured from the port strobe. The line legs, the loopback bit and the bit position must all match the reference, and the position must continue seamlessly across each wrap edge and each word boundary.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned CHAR_BITS  = 10;
  localparam int unsigned CHARS_WORD = 2;
  localparam int unsigned WORD_BITS  = CHAR_BITS * CHARS_WORD;
endpackage

// File: rtl/ser_word_timer.sv
module ser_word_timer #(
  parameter int unsigned WORD_W = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_o
);
  localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST_PHASE = CW'(WORD_W - 1);

  logic [CW-1:0] phase_q, phase_d;
  logic          armed_q, armed_d;

  always_comb begin
    armed_d = 1'b1;
    phase_d = phase_q;
    if (armed_q) begin
      if (phase_q == LAST_PHASE) phase_d = '0;
      else                       phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      armed_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      armed_q <= armed_d;
    end
  end

  assign load_o = armed_q && (phase_q == '0);

  // R2
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
  // R2
  load_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && phase_q == LAST_PHASE) |=> load_o);
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o,
  output logic              primed_o
);
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              primed_q, primed_d;

  always_comb begin
    primed_d = primed_q | load_i;
    if (load_i) sr_d = word_i;
    else        sr_d = {1'b0, sr_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      primed_q <= 1'b0;
    end else begin
      sr_q     <= sr_d;
      primed_q <= primed_d;
    end
  end

  assign ser_o    = sr_q[0];
  assign primed_o = primed_q;

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sr_q == $past(word_i)));
  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !load_i) |=> (sr_q[WORD_W-2:0] == $past(sr_q[WORD_W-1:1])));
endmodule

// File: rtl/ser_line_mux.sv
module ser_line_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic primed_i,
  input  logic ser_i,
  input  logic line_rx_i,
  output logic line_p_o,
  output logic line_n_o,
  output logic rx_o
);
  logic tx_bit;

  always_comb begin
    tx_bit   = primed_i ? ser_i : 1'b1;
    line_p_o = wrap_i | tx_bit;
    line_n_o = ~line_p_o;
    rx_o     = wrap_i ? tx_bit : line_rx_i;
  end

  // R6
  wrap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |-> (line_p_o && !line_n_o));
  // R7
  loop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && primed_i) |-> (rx_o == ser_i));
  // R8
  line_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_i && primed_i) |-> (line_p_o == ser_i && line_n_o == !ser_i));
endmodule

// File: rtl/ser_wrap_tx.sv
module ser_wrap_tx #(
  parameter int unsigned WORD_W = ser_pkg::WORD_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              wrap_en,
  input  logic              line_rx_in,
  output logic              word_load,
  output logic              line_p,
  output logic              line_n,
  output logic              rx_bit
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       ser_bit;
  logic       primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  ser_word_timer #(.WORD_W(WORD_W)) u_timer (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .load_o (word_load)
  );

  ser_shift_reg #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load_i   (word_load),
    .word_i   (word_in),
    .ser_o    (ser_bit),
    .primed_o (primed)
  );

  ser_line_mux u_mux (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wrap_i    (wrap_en),
    .primed_i  (primed),
    .ser_i     (ser_bit),
    .line_rx_i (line_rx_in),
    .line_p_o  (line_p),
    .line_n_o  (line_n),
    .rx_o      (rx_bit)
  );

  // R1
  idle_before_load_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !primed |-> (line_p && !line_n));
endmodule

// File: tb/ser_wrap_tx_tb.sv
`timescale 1ns/1ps
module ser_wrap_tx_tb;
  localparam int W = 20;
  localparam int RUN_CYCLES = 9000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] word_in;
  logic         wrap_en;
  logic         line_rx_in;
  logic         word_load, line_p, line_n, rx_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ser_wrap_tx u_dut (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .wrap_en(wrap_en),
    .line_rx_in(line_rx_in), .word_load(word_load), .line_p(line_p),
    .line_n(line_n), .rx_bit(rx_bit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] directed_word(input int n);
    case (n)
      0: return 20'hFFFFF;
      1: return 20'h00000;
      2: return 20'h00001;
      3: return 20'h80000;
      4: return 20'hAAAAA;
      5: return 20'h003FF;
      6: return 20'hFFC00;
      7: return 20'h0F83E;
      default: return 20'(W'($urandom));
    endcase
  endfunction

  function automatic bit wrap_pick(input int cyc, input bit cur);
    if (cyc < 2000) return 1'b0;
    if (cyc < 4000) return (($urandom % 4) == 0) ? !cur : cur;
    if (cyc < 5000) return 1'b1;
    if (cyc < 6000) return 1'b0;
    return (($urandom % 3) == 0) ? !cur : cur;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] cur;
    int  idx;
    bit  primed;
    int  gap;
    bit  seen_load;
    int  loads;
    bit  prev_wrap;
    logic exp_ser;
    string tag;

    void'($urandom(32'd20251));
    cur = '0; idx = 0; primed = 0; gap = 0; seen_load = 0; loads = 0;
    prev_wrap = 0;
    rst_n = 1'b0; word_in = '0; wrap_en = 1'b0; line_rx_in = 1'b0;

    repeat (4) begin
      @(negedge clk);
      chk(line_p == 1'b1 && line_n == 1'b0, "R1", "line idle in reset",
          {line_p, line_n}, 2'b10);
      chk(word_load == 1'b0, "R1", "no load in reset", word_load, 0);
      word_in = 20'(W'($urandom));
    end
    rst_n = 1'b1;

    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      exp_ser = (primed && idx < W) ? cur[idx] : 1'b1;

      if (!primed)
        chk(line_p == 1'b1 && line_n == 1'b0, "R1", "idle before first word",
            {line_p, line_n}, 2'b10);

      if (wrap_en) begin
        chk(line_p == 1'b1 && line_n == 1'b0, "R6", "line parked in wrap",
            {line_p, line_n}, 2'b10);
        chk(rx_bit == exp_ser, "R7", "loopback bit", rx_bit, exp_ser);
      end else begin
        if (prev_wrap)                 tag = "R9";
        else if (idx == 9 || idx == 10) tag = "R5";
        else                           tag = "R4";
        chk(line_p == exp_ser, tag, "line data bit", line_p, exp_ser);
        chk(line_n == !line_p, "R8", "line complement", line_n, !line_p);
        chk(rx_bit == line_rx_in, "R7", "external rx route", rx_bit, line_rx_in);
      end

      gap++;
      if (word_load) begin
        if (seen_load) chk(gap == W, "R2", "load spacing", gap, W);
        gap = 0;
        seen_load = 1;
      end

      prev_wrap  = wrap_en;
      wrap_en    = wrap_pick(cyc, wrap_en);
      line_rx_in = 1'($urandom);
      word_in    = word_load ? directed_word(loads) : 20'(W'($urandom));
      // R3: word_in changes every cycle; only the strobed value is modelled
      idx++;
      if (word_load) begin
        cur = word_in;
        idx = 0;
        primed = 1;
        loads++;
      end
    end

    chk(loads >= (RUN_CYCLES / W) - 1, "R2", "load count", loads, (RUN_CYCLES / W) - 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule